// File: doc/BRIEF.md
# Multiprocessor Hardware Lock Unit

This block gives four processing elements a set of lock variables held in flip-flops inside the unit, so taking or dropping a lock never touches main memory. Each processor has its own request lane carrying an operation (take or drop), a bank select and a lock number, so the unit always knows which processor is asking. The reply comes back on that processor's lane one clock later.

There are two banks. Short-section locks behave as spin locks: a refused processor simply retries. Long-section locks behave as blocking locks: a refused processor is entered in that lock's waiter set, and when the owner drops the lock the unit raises a one-cycle interrupt to the lowest-numbered waiter. That waiter then retries the take. Ownership belongs to the processor, not to any task, so a holder or waiter whose task is preempted keeps its place. A drop from any processor other than the owner changes nothing except a sticky error flag.

Top module: `hwlock_unit`

## Requirements
- R1: After reset every lock in both banks is free, no processor is waiting, and `pe_ack`, `pe_got`, `pe_irq` and `err_sticky` are all 0.
- R2: A take (`pe_rel`=0) of a free lock is granted: in the cycle after the request `pe_ack` and `pe_got` for that processor are both 1, and the requester becomes the owner.
- R3: A take of a held lock is refused: the next cycle shows `pe_ack`=1 and `pe_got`=0 for that processor, and ownership does not change.
- R4: A drop (`pe_rel`=1) by the owner frees the lock, so a later take by any processor is granted.
- R5: A drop by a processor that is not the owner, including a drop of a free lock, leaves the lock state unchanged and sets `err_sticky` to 1 from the next cycle until reset.
- R6: When several processors take the same free lock in one cycle, only the lowest processor index is granted; the others are refused.
- R7: The short bank (`pe_long`=0) keeps no waiters: a refused take records nothing and a drop raises no interrupt.
- R8: In the long bank (`pe_long`=1) a refused take adds the processor to the lock's waiters; a drop by the owner pulses `pe_irq` of the lowest-numbered waiter for exactly one cycle, in the same cycle as the drop's `pe_ack`, and removes it from the waiters, so successive drops wake the remaining waiters in ascending index order.
- R9: Short lock k and long lock k are distinct locks; holding one does not affect the other.
- R10: A processor may hold several locks at once, and each stays owned by it, whatever other requests it makes, until that processor drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pe_req | input | 4 | Per-processor request strobe, one cycle per request |
| pe_rel | input | 4 | Per-processor operation: 0 take, 1 drop |
| pe_long | input | 4 | Per-processor bank: 0 short spin bank, 1 long blocking bank |
| pe_lock | input | 24 | Per-processor lock number, processor p in bits [6p+5:6p] |
| pe_ack | output | 4 | Reply valid, one cycle after the request |
| pe_got | output | 4 | Take granted (meaningful with `pe_ack`) |
| pe_irq | output | 4 | One-cycle wake pulse for a waiting processor |
| err_sticky | output | 1 | Set by a drop from a non-owner, cleared only by reset |

## Verification
Every lock of both banks is swept with a grant, a refusal by a second processor and a drop by the owner, which separates a lock that is decoded to the wrong bank or number from one that works. All fifteen non-empty sets of simultaneous takers are applied to one lock in each bank, telling a correct lowest-index tie-break from any other order and showing which refused processors get woken. A dedicated sequence queues three waiters out of order on one long lock and drains them, distinguishing ascending wake order from arrival order, and a long run of pseudo-random traffic on four locks compares every reply, wake and the error flag with a cycle-level model built from the requirements.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int unsigned PE_N  = 4;
  localparam int unsigned PE_IW = $clog2(PE_N);

  typedef logic [PE_N-1:0]  pe_vec_t;
  typedef logic [PE_IW-1:0] pe_id_t;

  // keep only the lowest set bit (fixed priority: index 0 first)
  function automatic pe_vec_t first_set(pe_vec_t v);
    return v & (~v + pe_vec_t'(1));
  endfunction

  function automatic pe_id_t vec_to_id(pe_vec_t v);
    pe_id_t id = '0;
    for (int i = 0; i < PE_N; i++) begin
      if (v[i]) id = pe_id_t'(i);
    end
    return id;
  endfunction

  function automatic pe_vec_t id_to_vec(pe_id_t id);
    return pe_vec_t'(1) << id;
  endfunction
endpackage

// File: rtl/hwlock_cell.sv
module hwlock_cell
  import hwlock_pkg::*;
#(
  parameter bit BLOCKING = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  pe_vec_t acq_hit,
  input  pe_vec_t rel_hit,
  output pe_vec_t win,
  output pe_vec_t wake,
  output pe_vec_t misuse,
  output logic    freed
);
  logic    held;
  pe_id_t  owner;
  pe_vec_t owner_vec;
  pe_vec_t waiting;
  pe_vec_t pend;

  always_comb begin
    win       = held ? '0 : first_set(acq_hit);
    owner_vec = held ? id_to_vec(owner) : '0;
    freed     = |(rel_hit & owner_vec);
    misuse    = rel_hit & ~owner_vec;
    pend      = BLOCKING ? (waiting | (acq_hit & ~win)) : '0;
    wake      = freed ? first_set(pend) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      owner <= '0;
    end else if (|win) begin
      held  <= 1'b1;
      owner <= vec_to_id(win);
    end else if (freed) begin
      held  <= 1'b0;
    end
  end

  if (BLOCKING) begin : g_wait
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) waiting <= '0;
      else        waiting <= pend & ~wake;
    end
  end else begin : g_nowait
    assign waiting = '0;
  end
endmodule

// File: rtl/hwlock_unit.sv
module hwlock_unit
  import hwlock_pkg::*;
#(
  parameter  int NSHORT = 64,
  parameter  int NLONG  = 64,
  localparam int NMAX   = (NSHORT > NLONG) ? NSHORT : NLONG,
  localparam int IW     = (NMAX > 1) ? $clog2(NMAX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PE_N-1:0]    pe_req,
  input  logic [PE_N-1:0]    pe_rel,
  input  logic [PE_N-1:0]    pe_long,
  input  logic [PE_N*IW-1:0] pe_lock,
  output logic [PE_N-1:0]    pe_ack,
  output logic [PE_N-1:0]    pe_got,
  output logic [PE_N-1:0]    pe_irq,
  output logic               err_sticky
);
  logic [IW-1:0] pe_idx [PE_N];
  pe_vec_t take_v, drop_v;

  always_comb begin
    for (int p = 0; p < PE_N; p++) begin
      pe_idx[p] = pe_lock[p*IW +: IW];
      take_v[p] = pe_req[p] && !pe_rel[p];
      drop_v[p] = pe_req[p] &&  pe_rel[p];
    end
  end

  pe_vec_t s_win [NSHORT];
  pe_vec_t s_wake[NSHORT];
  pe_vec_t s_mis [NSHORT];
  logic [NSHORT-1:0] s_free;
  pe_vec_t l_win [NLONG];
  pe_vec_t l_wake[NLONG];
  pe_vec_t l_mis [NLONG];
  logic [NLONG-1:0] l_free;

  for (genvar s = 0; s < NSHORT; s++) begin : g_short
    pe_vec_t hit;
    always_comb begin
      for (int p = 0; p < PE_N; p++) hit[p] = !pe_long[p] && (pe_idx[p] == IW'(s));
    end
    hwlock_cell #(.BLOCKING(1'b0)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .acq_hit(take_v & hit), .rel_hit(drop_v & hit),
      .win(s_win[s]), .wake(s_wake[s]), .misuse(s_mis[s]), .freed(s_free[s])
    );
  end

  for (genvar l = 0; l < NLONG; l++) begin : g_long
    pe_vec_t hit;
    always_comb begin
      for (int p = 0; p < PE_N; p++) hit[p] = pe_long[p] && (pe_idx[p] == IW'(l));
    end
    hwlock_cell #(.BLOCKING(1'b1)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .acq_hit(take_v & hit), .rel_hit(drop_v & hit),
      .win(l_win[l]), .wake(l_wake[l]), .misuse(l_mis[l]), .freed(l_free[l])
    );
  end

  // named internal events, observed by the bound checker
  pe_vec_t grant_all, wake_all, misuse_all;
  logic    bad_any, long_rel_evt, short_rel_evt;

  always_comb begin
    grant_all  = '0;
    wake_all   = '0;
    misuse_all = '0;
    for (int s = 0; s < NSHORT; s++) begin
      grant_all  |= s_win[s];
      wake_all   |= s_wake[s];
      misuse_all |= s_mis[s];
    end
    for (int l = 0; l < NLONG; l++) begin
      grant_all  |= l_win[l];
      wake_all   |= l_wake[l];
      misuse_all |= l_mis[l];
    end
    bad_any       = |misuse_all;
    long_rel_evt  = |l_free;
    short_rel_evt = |s_free;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_ack     <= '0;
      pe_got     <= '0;
      pe_irq     <= '0;
      err_sticky <= 1'b0;
    end else begin
      pe_ack     <= pe_req;
      pe_got     <= grant_all;
      pe_irq     <= wake_all;
      err_sticky <= err_sticky | bad_any;
    end
  end
endmodule

// File: rtl/hwlock_check.sv
module hwlock_check
  import hwlock_pkg::*;
#(
  parameter int IW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PE_N-1:0]    pe_req,
  input logic [PE_N-1:0]    pe_rel,
  input logic [PE_N-1:0]    pe_long,
  input logic [PE_N*IW-1:0] pe_lock,
  input logic [PE_N-1:0]    pe_ack,
  input logic [PE_N-1:0]    pe_got,
  input logic [PE_N-1:0]    pe_irq,
  input logic               err_sticky,
  input logic               bad_any,
  input logic               long_rel_evt,
  input logic               short_rel_evt
);
  AST_GOT_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_got & ~pe_ack) == '0);  // R2

  for (genvar p = 0; p < PE_N; p++) begin : g_pe
    AST_GOT_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pe_req[p] && !pe_rel[p]) |=> !pe_got[p]);  // R3
  end

  for (genvar i = 0; i < PE_N; i++) begin : g_i
    for (genvar j = i + 1; j < PE_N; j++) begin : g_j
      AST_TIE_LOWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_req[i] && !pe_rel[i] && pe_req[j] && !pe_rel[j] &&
         pe_long[i] == pe_long[j] &&
         pe_lock[i*IW +: IW] == pe_lock[j*IW +: IW]) |=> !pe_got[j]);  // R6
    end
  end

  AST_WAKE_NEEDS_LONG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !long_rel_evt |=> pe_irq == '0);  // R8

  AST_SHORT_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (short_rel_evt && !long_rel_evt) |=> pe_irq == '0);  // R7

  AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);  // R5

  AST_MISUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_any |=> err_sticky);  // R5
endmodule

bind hwlock_unit hwlock_check #(.IW(IW)) u_hwlock_check (
  .clk(clk), .rst_n(rst_n),
  .pe_req(pe_req), .pe_rel(pe_rel), .pe_long(pe_long), .pe_lock(pe_lock),
  .pe_ack(pe_ack), .pe_got(pe_got), .pe_irq(pe_irq), .err_sticky(err_sticky),
  .bad_any(bad_any), .long_rel_evt(long_rel_evt), .short_rel_evt(short_rel_evt)
);

// File: tb/test_hwlock_unit.sv
`timescale 1ns/1ps
module test_hwlock_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pe_req = '0, pe_rel = '0, pe_long = '0;
  logic [23:0] pe_lock = '0;
  logic [3:0]  pe_ack, pe_got, pe_irq;
  logic        err_sticky;

  int nvec = 0, nfail = 0;
  bit finished = 0;

  // requirement-level model state
  int         own_s [64];
  int         own_l [64];
  logic [3:0] wt_l  [64];
  logic       err_m = 1'b0;

  always #2.5 clk = ~clk;

  hwlock_unit i_hwlock_unit (
    .clk(clk), .rst_n(rst_n), .pe_req(pe_req), .pe_rel(pe_rel),
    .pe_long(pe_long), .pe_lock(pe_lock), .pe_ack(pe_ack), .pe_got(pe_got),
    .pe_irq(pe_irq), .err_sticky(err_sticky)
  );

  function automatic logic [23:0] pk(int a, int b, int c, int d);
    return {d[5:0], c[5:0], b[5:0], a[5:0]};
  endfunction

  function automatic logic [3:0] bitp(int p);
    return 4'b0001 << p;
  endfunction

  task automatic cyc(input logic [3:0] r, input logic [3:0] rl,
                     input logic [3:0] lg, input logic [23:0] ix, input string tag);
    logic [3:0] e_got = '0, e_irq = '0;
    @(negedge clk);
    pe_req = r; pe_rel = rl; pe_long = lg; pe_lock = ix;
    // takes see the state before this cycle; lower index claims first
    for (int p = 0; p < 4; p++) begin
      int k = int'(ix[p*6 +: 6]);
      if (r[p] && !rl[p]) begin
        if (lg[p]) begin
          if (own_l[k] < 0) begin own_l[k] = p; e_got[p] = 1'b1; end
          else wt_l[k][p] = 1'b1;
        end else begin
          if (own_s[k] < 0) begin own_s[k] = p; e_got[p] = 1'b1; end
        end
      end
    end
    for (int p = 0; p < 4; p++) begin
      int k = int'(ix[p*6 +: 6]);
      if (r[p] && rl[p]) begin
        if (lg[p]) begin
          if (own_l[k] == p) begin
            own_l[k] = -1;
            for (int q = 0; q < 4; q++) begin
              if (wt_l[k][q]) begin e_irq[q] = 1'b1; wt_l[k][q] = 1'b0; break; end
            end
          end else err_m = 1'b1;
        end else begin
          if (own_s[k] == p) own_s[k] = -1;
          else err_m = 1'b1;
        end
      end
    end
    @(posedge clk);
    #1;
    nvec++;
    if (pe_ack !== r || pe_got !== e_got || pe_irq !== e_irq || err_sticky !== err_m) begin
      nfail++;
      $display("FAIL %s: ack/got/irq/err = %b/%b/%b/%b expected %b/%b/%b/%b",
               tag, pe_ack, pe_got, pe_irq, err_sticky, r, e_got, e_irq, err_m);
    end
    pe_req = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int p, q;
    logic [31:0] seed = 32'h1234_5678;
    for (int k = 0; k < 64; k++) begin own_s[k] = -1; own_l[k] = -1; wt_l[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    nvec++;
    if (pe_ack !== 0 || pe_got !== 0 || pe_irq !== 0 || err_sticky !== 0) begin
      nfail++;
      $display("FAIL R1: ack/got/irq/err = %b/%b/%b/%b expected 0000/0000/0000/0",
               pe_ack, pe_got, pe_irq, err_sticky);
    end

    // R1 R2: every lock in both banks starts free and is granted
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 64; k++) begin
        p = k % 4;
        cyc(bitp(p), 4'b0, b ? bitp(p) : 4'b0, pk(k, k, k, k), "R2");
      end
    // R3: a second processor is refused (long bank records a waiter)
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 64; k++) begin
        q = (k + 1) % 4;
        cyc(bitp(q), 4'b0, b ? bitp(q) : 4'b0, pk(k, k, k, k), "R3");
      end
    // R7 R8: owner drops; long bank wakes the refused processor
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 64; k++) begin
        p = k % 4;
        cyc(bitp(p), bitp(p), b ? bitp(p) : 4'b0, pk(k, k, k, k), b ? "R8" : "R7");
      end
    // R4: freed lock is granted to a third processor, then dropped
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 64; k++) begin
        q = (k + 2) % 4;
        cyc(bitp(q), 4'b0, b ? bitp(q) : 4'b0, pk(k, k, k, k), "R4");
        cyc(bitp(q), bitp(q), b ? bitp(q) : 4'b0, pk(k, k, k, k), "R4");
      end
    // R6: every set of simultaneous takers on one lock
    for (int b = 0; b < 2; b++)
      for (int m = 1; m < 16; m++) begin
        logic [3:0] mv = 4'(m);
        logic [3:0] w  = mv & (~mv + 4'd1);
        cyc(mv, 4'b0, b ? mv : 4'b0, pk(5, 5, 5, 5), "R6");
        cyc(w, w, b ? w : 4'b0, pk(5, 5, 5, 5), "R6");
      end
    // R8: waiters queued out of order are woken in ascending index order
    cyc(4'b0001, 4'b0, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b1000, 4'b0, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b0010, 4'b0, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b0100, 4'b0, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b0001, 4'b0001, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b0010, 4'b0, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b0010, 4'b0010, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b0100, 4'b0, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b0100, 4'b0100, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b1000, 4'b0, 4'b1111, pk(9, 9, 9, 9), "R8");
    cyc(4'b1000, 4'b1000, 4'b1111, pk(9, 9, 9, 9), "R8");
    // R9: short 7 and long 7 are separate locks
    cyc(4'b0110, 4'b0, 4'b0100, pk(7, 7, 7, 7), "R9");
    cyc(4'b0110, 4'b0110, 4'b0100, pk(7, 7, 7, 7), "R9");
    // R10: one processor holds several locks across other traffic
    cyc(4'b0001, 4'b0, 4'b0000, pk(1, 0, 0, 0), "R10");
    cyc(4'b0001, 4'b0, 4'b0000, pk(2, 0, 0, 0), "R10");
    cyc(4'b0001, 4'b0, 4'b0001, pk(3, 0, 0, 0), "R10");
    cyc(4'b1110, 4'b0, 4'b1000, pk(0, 1, 2, 3), "R10");
    cyc(4'b0001, 4'b0001, 4'b0000, pk(2, 0, 0, 0), "R10");
    cyc(4'b0001, 4'b0001, 4'b0001, pk(3, 0, 0, 0), "R10");
    cyc(4'b0001, 4'b0001, 4'b0000, pk(1, 0, 0, 0), "R10");
    // R5: foreign drop is ignored and flags an error that stays set
    cyc(4'b0001, 4'b0, 4'b0001, pk(20, 0, 0, 0), "R5");
    cyc(4'b1000, 4'b1000, 4'b1000, pk(0, 0, 0, 20), "R5");
    cyc(4'b1000, 4'b0, 4'b1000, pk(0, 0, 0, 20), "R5");
    cyc(4'b0001, 4'b0001, 4'b0001, pk(20, 0, 0, 0), "R5");
    cyc(4'b0010, 4'b0010, 4'b0000, pk(0, 30, 0, 0), "R5");
    // mixed pseudo-random traffic on a few contended locks
    for (int t = 0; t < 3000; t++) begin
      logic [3:0] r, rl, lg;
      seed = seed * 32'd1664525 + 32'd1013904223;
      r  = seed[31:28];
      rl = seed[27:24] & seed[23:20];
      lg = seed[19:16];
      cyc(r, rl, lg, pk(int'(seed[15:14]), int'(seed[13:12]),
                        int'(seed[11:10]), int'(seed[9:8])), "R2");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule